// File: doc/BRIEF.md
# Seconds Real-Time Clock with Match Alarm

This block is a real-time clock peripheral on a simple 32-bit peripheral register bus with a select, an enable phase and a write flag, in the style of APB. It keeps a free-running 32-bit count of seconds. The count advances by one on every cycle in which a one-cycle tick strobe from an outside prescaler is high. Software can overwrite the count through a load register, and it can program a match value.

When the count becomes equal to the match value, the block sets a raw alarm flag. A one-bit mask gates that flag onto a level interrupt output, and a write-one-to-clear register drops the flag again. A load or match write that leaves the two values equal also sets the flag in the same edge, even when they were already equal. A control word always reads as enabled. A bank of eight byte-wide identification words sits at the top of the 4 KB window.

Address bits [1:0] are ignored. A write takes effect on the rising clock edge where psel, penable and pwrite are all high. Read data is combinational from paddr. The asynchronous active-low reset is released synchronously inside the block, so it takes two clock edges to leave reset.

Top module: `sec_rtc`

## Requirements
- R1: After reset the count, match, load, mask and raw flag read 0 and irq is 0. The count already equals the match value at reset, but no alarm is raised for it.
- R2: The count is read at offset 0x00. It rises by exactly 1 on each clock edge where tick is high and no load write occurs, it wraps from 0xFFFFFFFF to 0, and it holds otherwise.
- R3: A write to offset 0x08 replaces the count with the written value on that edge, even if tick is high in the same cycle. Reading 0x08 returns the last value written there, not the running count.
- R4: Offset 0x04 holds the match value (read/write). The raw flag (bit 0 of offset 0x14) sets on the edge where a tick brings the count equal to the match value, including when the count wraps to 0.
- R5: A match or load write that leaves count equal to match sets the raw flag on that write's edge, even when the two values were already equal before the write.
- R6: The raw flag sets only on entry into equality. Once cleared while count and match stay equal, it stays 0 until the next entry or retriggering write.
- R7: Offset 0x10 stores only bit 0 of a write as the mask, and bits [31:1] read 0. Offset 0x18 reads raw AND mask in bit 0, and irq drives the same level.
- R8: Writing 1 in bit 0 to offset 0x1C clears the raw flag, and writing 0 there leaves it unchanged. If the flag sets in the same cycle as a clear write, the set wins.
- R9: Offset 0x0C always reads 1 and ignores writes. Writes to 0x00, 0x14, 0x18 and to unmapped offsets change nothing. Reads of 0x1C and of unmapped offsets return 0.
- R10: Offsets 0xFE0 to 0xFFC each return one byte in bits [7:0], chosen by (offset - 0xFE0) >> 2, in the sequence 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | One-cycle seconds strobe from the prescaler |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access (second) phase of a transfer |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | 12 | Byte address in the 4 KB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data for paddr |
| irq | output | 1 | Level alarm interrupt (raw AND mask) |

## Verification
Two pairs of functions can fall in the same cycle. A tick can arrive during a load write, and an alarm set caused by a tick can arrive during a clear write. The bench provokes each pair by raising tick during the enable phase of the write. It judges the load case by reading back the written value rather than the written value plus one. It judges the clear case by finding the raw flag still set, after first loading the count one below the match value.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;

  // word indexes (byte offset >> 2) of the mapped registers
  localparam int unsigned W_COUNT  = 0;
  localparam int unsigned W_MATCH  = 1;
  localparam int unsigned W_LOAD   = 2;
  localparam int unsigned W_CTRL   = 3;
  localparam int unsigned W_MASK   = 4;
  localparam int unsigned W_RAW    = 5;
  localparam int unsigned W_MASKED = 6;
  localparam int unsigned W_CLEAR  = 7;

  localparam int unsigned ID_COUNT = 8;
  localparam int unsigned ID_SEL_W = $clog2(ID_COUNT);

  typedef struct packed {
    logic load;
    logic match;
    logic mask;
    logic clear;
  } wr_strobe_t;

  function automatic logic [7:0] id_byte(input logic [ID_SEL_W-1:0] sel);
    logic [7:0] b;
    case (sel)
      3'd0:    b = 8'h31;
      3'd1:    b = 8'h10;
      3'd2:    b = 8'h14;
      3'd3:    b = 8'h00;
      3'd4:    b = 8'h0D;
      3'd5:    b = 8'hF0;
      3'd6:    b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/sec_rtc_rst_sync.sv
module sec_rtc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/sec_rtc_regif.sv
module sec_rtc_regif
  import sec_rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] count_val,
  input  logic [DATA_W-1:0] match_val,
  input  logic [DATA_W-1:0] load_val,
  input  logic              mask_bit,
  input  logic              raw_bit,
  output wr_strobe_t        wr_strb,
  output logic [DATA_W-1:0] prdata
);

  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam int unsigned WIN_LO = 2 + ID_SEL_W;

  logic              wr_acc;
  logic [WORD_W-1:0] word;
  logic              in_id_win;
  logic [ID_SEL_W-1:0] id_sel;

  assign wr_acc    = psel & penable & pwrite;
  assign word      = paddr[ADDR_W-1:2];
  assign in_id_win = &paddr[ADDR_W-1:WIN_LO];
  assign id_sel    = paddr[WIN_LO-1:2];

  always_comb begin
    wr_strb       = '0;
    wr_strb.load  = wr_acc && (int'(word) == W_LOAD);
    wr_strb.match = wr_acc && (int'(word) == W_MATCH);
    wr_strb.mask  = wr_acc && (int'(word) == W_MASK);
    wr_strb.clear = wr_acc && (int'(word) == W_CLEAR);
  end

  always_comb begin
    prdata = '0;
    if (in_id_win) begin
      prdata[7:0] = id_byte(id_sel);
    end else begin
      case (int'(word))
        W_COUNT:  prdata = count_val;
        W_MATCH:  prdata = match_val;
        W_LOAD:   prdata = load_val;
        W_CTRL:   prdata[0] = 1'b1;
        W_MASK:   prdata[0] = mask_bit;
        W_RAW:    prdata[0] = raw_bit;
        W_MASKED: prdata[0] = raw_bit & mask_bit;
        default:  prdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/sec_rtc_counter.sv
module sec_rtc_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              tick,
  input  logic              load_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] count_q,
  output logic [DATA_W-1:0] count_d,
  output logic [DATA_W-1:0] load_q
);

  logic              count_en;
  logic [DATA_W-1:0] load_d;

  always_comb begin
    count_en = load_wr | tick;
    count_d  = count_q;
    if (load_wr) begin
      count_d = wdata;
    end else if (tick) begin
      count_d = count_q + 1'b1;
    end
    load_d = load_wr ? wdata : load_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= '0;
    end else if (load_wr) begin
      load_q <= load_d;
    end
  end

  // R3
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    load_wr |=> (count_q == $past(wdata)));

  // R2
  tick_step_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (tick && !load_wr) |=> (count_q == $past(count_q) + 1'b1));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!tick && !load_wr) |=> $stable(count_q));

endmodule

// File: rtl/sec_rtc_alarm.sv
module sec_rtc_alarm #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              match_wr,
  input  logic              load_wr,
  input  logic              mask_wr,
  input  logic              clear_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] count_q,
  input  logic [DATA_W-1:0] count_d,
  output logic [DATA_W-1:0] match_q,
  output logic              mask_q,
  output logic              raw_q,
  output logic              irq
);

  logic [DATA_W-1:0] match_d;
  logic              eq_d;
  logic              eq_q;
  logic              retrig;
  logic              set_evt;
  logic              clr_evt;
  logic              raw_d;
  logic              mask_d;

  always_comb begin
    match_d = match_wr ? wdata : match_q;
    eq_d    = (count_d == match_d);
    retrig  = match_wr | load_wr;
    set_evt = eq_d & (~eq_q | retrig);
    clr_evt = clear_wr & wdata[0];
    raw_d   = set_evt | (raw_q & ~clr_evt);
    mask_d  = mask_wr ? wdata[0] : mask_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= '0;
    end else if (match_wr) begin
      match_q <= match_d;
    end
  end

  // reset state has count == match, so the tracker starts as equal
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      eq_q  <= 1'b1;
      raw_q <= 1'b0;
    end else begin
      eq_q  <= eq_d;
      raw_q <= raw_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= 1'b0;
    end else if (mask_wr) begin
      mask_q <= mask_d;
    end
  end

  assign irq = raw_q & mask_q;

  // R4
  entry_sets_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ((count_d == match_d) && (count_q != match_q)) |=> raw_q);

  // R6
  no_reentry_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (clear_wr && wdata[0] && !match_wr && !load_wr && (count_q == match_q)) |=> !raw_q);

  // R8
  raw_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (raw_q && !clear_wr) |=> raw_q);

  // R7
  mask_bit0_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    mask_wr |=> (mask_q == $past(wdata[0])));

endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
  import sec_rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              irq
);

  logic              rst_ni;
  wr_strobe_t        strb;
  logic [DATA_W-1:0] count_q;
  logic [DATA_W-1:0] count_d;
  logic [DATA_W-1:0] load_q;
  logic [DATA_W-1:0] match_q;
  logic              mask_q;
  logic              raw_q;

  sec_rtc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ni)
  );

  sec_rtc_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .count_val (count_q),
    .match_val (match_q),
    .load_val  (load_q),
    .mask_bit  (mask_q),
    .raw_bit   (raw_q),
    .wr_strb   (strb),
    .prdata    (prdata)
  );

  sec_rtc_counter #(.DATA_W(DATA_W)) u_counter (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .tick    (tick),
    .load_wr (strb.load),
    .wdata   (pwdata),
    .count_q (count_q),
    .count_d (count_d),
    .load_q  (load_q)
  );

  sec_rtc_alarm #(.DATA_W(DATA_W)) u_alarm (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .match_wr (strb.match),
    .load_wr  (strb.load),
    .mask_wr  (strb.mask),
    .clear_wr (strb.clear),
    .wdata    (pwdata),
    .count_q  (count_q),
    .count_d  (count_d),
    .match_q  (match_q),
    .mask_q   (mask_q),
    .raw_q    (raw_q),
    .irq      (irq)
  );

endmodule

// File: tb/sec_rtc_tb.sv
module sec_rtc_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick;
  logic        psel;
  logic        penable;
  logic        pwrite;
  logic [11:0] paddr;
  logic [31:0] pwdata;
  logic [31:0] prdata;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sec_rtc u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // write; tick_too raises tick in the enable-phase cycle
  task automatic wr(input logic [11:0] a, input logic [31:0] d, input bit tick_too = 1'b0);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1; tick = tick_too;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; tick = 1'b0; pwdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a;
    #1 d = prdata;
    psel = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic t_reset();
    rd_chk("R1 count", 12'h000, 32'h0);
    rd_chk("R1 match", 12'h004, 32'h0);
    rd_chk("R1 load",  12'h008, 32'h0);
    rd_chk("R1 mask",  12'h010, 32'h0);
    rd_chk("R1 raw",   12'h014, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_count();
    wr(12'h004, 32'h0000_1000);
    wr(12'h008, 32'h0000_0100);
    pulse_tick(); pulse_tick(); pulse_tick();
    rd_chk("R2 three ticks", 12'h000, 32'h0000_0103);
    repeat (5) @(negedge clk);
    rd_chk("R2 hold", 12'h000, 32'h0000_0103);
    rd_chk("R3 load readback", 12'h008, 32'h0000_0100);
    rd_chk("R4 match readback", 12'h004, 32'h0000_1000);
  endtask

  task automatic t_load_vs_tick();
    wr(12'h008, 32'h0000_0500, 1'b1);
    rd_chk("R3 load wins over tick", 12'h000, 32'h0000_0500);
  endtask

  task automatic t_match_tick();
    wr(12'h004, 32'h0000_0502);
    rd_chk("R4 no raw before match", 12'h014, 32'h0);
    pulse_tick();
    rd_chk("R4 raw still 0 one below", 12'h014, 32'h0);
    pulse_tick();
    rd_chk("R4 raw on match by tick", 12'h014, 32'h1);
    wr(12'h01C, 32'h1);
    rd_chk("R8 clear one", 12'h014, 32'h0);
  endtask

  task automatic t_wrap();
    wr(12'h004, 32'h0);
    wr(12'h008, 32'hFFFF_FFFF);
    rd_chk("R4 no raw after load ffffffff", 12'h014, 32'h0);
    pulse_tick();
    rd_chk("R2 wrap to 0", 12'h000, 32'h0);
    rd_chk("R4 raw on wrap", 12'h014, 32'h1);
    wr(12'h01C, 32'h1);
  endtask

  task automatic t_write_trigger();
    wr(12'h008, 32'h0000_0020);
    wr(12'h004, 32'h0000_0020);
    rd_chk("R5 match write equal", 12'h014, 32'h1);
    wr(12'h01C, 32'h1);
    repeat (4) @(negedge clk);
    rd_chk("R6 stays clear while equal", 12'h014, 32'h0);
    wr(12'h004, 32'h0000_0020);
    rd_chk("R5 rewrite same match", 12'h014, 32'h1);
    wr(12'h01C, 32'h0);
    rd_chk("R8 clear zero keeps", 12'h014, 32'h1);
    wr(12'h01C, 32'h1);
    wr(12'h008, 32'h0000_0020);
    rd_chk("R5 load write equal", 12'h014, 32'h1);
    wr(12'h01C, 32'h1);
  endtask

  task automatic t_mask();
    wr(12'h010, 32'hFFFF_FFFE);
    rd_chk("R7 mask bit0 only (0)", 12'h010, 32'h0);
    wr(12'h004, 32'h0000_0020);
    rd_chk("R7 masked zero", 12'h018, 32'h0);
    chk("R7 irq masked", {31'b0, irq}, 32'h0);
    wr(12'h010, 32'hFFFF_FFFF);
    rd_chk("R7 mask bit0 only (1)", 12'h010, 32'h1);
    rd_chk("R7 masked one", 12'h018, 32'h1);
    chk("R7 irq high", {31'b0, irq}, 32'h1);
    wr(12'h01C, 32'h1);
    chk("R7 irq low after clear", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_set_vs_clear();
    wr(12'h004, 32'h0000_0040);
    wr(12'h008, 32'h0000_003F);
    wr(12'h01C, 32'h1, 1'b1);
    rd_chk("R8 set wins over clear", 12'h014, 32'h1);
    rd_chk("R8 count reached match", 12'h000, 32'h0000_0040);
    wr(12'h01C, 32'h1);
  endtask

  task automatic t_ignored();
    wr(12'h00C, 32'h0);
    rd_chk("R9 ctrl reads 1", 12'h00C, 32'h1);
    wr(12'h000, 32'h1234_5678);
    wr(12'h014, 32'h1);
    wr(12'h018, 32'h1);
    wr(12'h020, 32'hAAAA_AAAA);
    wr(12'h800, 32'h5555_5555);
    rd_chk("R9 count unchanged", 12'h000, 32'h0000_0040);
    rd_chk("R9 raw unchanged", 12'h014, 32'h0);
    rd_chk("R9 match unchanged", 12'h004, 32'h0000_0040);
    rd_chk("R9 load unchanged", 12'h008, 32'h0000_003F);
    rd_chk("R9 mask unchanged", 12'h010, 32'h1);
    rd_chk("R9 clear reads 0", 12'h01C, 32'h0);
    rd_chk("R9 unmapped reads 0", 12'h024, 32'h0);
    rd_chk("R9 below id reads 0", 12'hFDC, 32'h0);
  endtask

  task automatic t_id();
    logic [7:0] exp_id [8] = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int i = 0; i < 8; i++) begin
      rd_chk($sformatf("R10 id %0d", i), 12'hFE0 + 12'(i*4), {24'h0, exp_id[i]});
    end
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b0; psel = 1'b0; penable = 1'b0;
    pwrite = 1'b0; paddr = '0; pwdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_count();
    t_load_vs_tick();
    t_match_tick();
    t_wrap();
    t_write_trigger();
    t_mask();
    t_set_vs_clear();
    t_ignored();
    t_id();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule